// File: doc/BRIEF.md
# External Interrupt Sense and Flag Controller

The block watches six external interrupt request pins. Each pin has a two-bit sense-mode field that picks one of four trigger conditions: the pin being low, a falling edge, a rising edge, or either edge. When the chosen condition is seen, the block sets that pin's status flag. A per-source enable bit gates the flag onto a per-source interrupt request line. Priority arbitration and vectoring are outside the block and handle these request lines.

Software reaches the enable bits, the status flags and the sense-mode fields over a simple synchronous register bus. A flag is cleared in one of three ways. Software can write 0 to it, but only after it has read that flag as 1. The processor can acknowledge the source, which is subject to a pin check in level mode. A data-transfer controller can service the source, unless its keep-interrupt control is raised. Each pin passes through a two-flop synchronizer before detection.

Top module: `ext_irq_sense`

## Requirements
- R1: After reset the enable register, the status register and both sense-mode registers read 0, and every `irq_o` bit is 0.
- R2: Register addresses are as follows. Address 0 holds the enable bits in bits 5..0. Address 1 holds the status flags in bits 5..0. Address 2 holds the sense fields {B,A} of sources 0..3, with source n at bits [2n+1:2n]. Address 3 holds the fields of sources 4 and 5 in bits [1:0] and [3:2]. All unimplemented bits read 0, and writes to them are ignored.
- R3: Each `irq_o[n]` is high in the same cycle as flag n AND enable bit n, and is low whenever the enable bit is 0.
- R4: The sense field encoding is 00 for low level, 01 for a falling edge, 10 for a rising edge and 11 for both edges. A pin change driven before rising edge k shows in the flag after rising edge k+2, and not after edge k+1.
- R5: In a single-edge mode, a transition of the opposite direction does not set the flag.
- R6: A status write of 0 to bit n clears flag n only if flag n was read as 1 since it was last set. Writing 1 has no effect, and writing 0 without a prior read of 1 has no effect.
- R7: A pulse on `ack_cpu_i[n]` while source n is in any edge mode clears flag n at the next clock edge.
- R8: A pulse on `ack_cpu_i[n]` while source n is in low-level mode clears the flag only if the synchronized pin is high. Otherwise the flag stays set.
- R9: A pulse on `dtc_ack_i[n]` clears flag n when `dtc_keep_i` is 0, and leaves it set when `dtc_keep_i` is 1.
- R10: When a set condition and any clear event fall in the same cycle, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_i | input | 6 | External request pins, asynchronous |
| bus_sel | input | 1 | Bus access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid in the cycle of the access |
| ack_cpu_i | input | 6 | Per-source processor acknowledge pulse |
| dtc_ack_i | input | 6 | Per-source transfer-controller service pulse |
| dtc_keep_i | input | 1 | 1 = leave flag set on transfer-controller service |
| irq_o | output | 6 | Per-source interrupt request |

## Verification
A pin change driven on a falling clock edge reaches the flag after the third following rising edge. The bench samples the flag on the second falling edge, where it must still be clear, and on the third, where it must be set. Bus writes, acknowledges and transfer-controller pulses take effect at the next rising edge, so their effect is sampled on the falling edge that follows. Read data and `irq_o` are combinational from the registers and are sampled mid-cycle. The set-wins case lines an acknowledge pulse up with the cycle in which a detected edge is pending.

// File: rtl/ext_irq_sense.sv
module ext_irq_sense #(
  parameter int NSRC     = 6,
  parameter int AW       = 2,
  parameter int ADDR_EN  = 0,
  parameter int ADDR_ST  = 1,
  parameter int ADDR_MLO = 2,
  parameter int ADDR_MHI = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] pin_i,
  input  logic            bus_sel,
  input  logic            bus_wr,
  input  logic [AW-1:0]   bus_addr,
  input  logic [7:0]      bus_wdata,
  output logic [7:0]      bus_rdata,
  input  logic [NSRC-1:0] ack_cpu_i,
  input  logic [NSRC-1:0] dtc_ack_i,
  input  logic            dtc_keep_i,
  output logic [NSRC-1:0] irq_o
);
  localparam int MW  = 2 * NSRC;
  localparam int HIW = MW - 8;

  logic [NSRC-1:0] en_q, flag_q, seen_q, s1_q, s2_q, prev_q;
  logic [MW-1:0]   mode_q;
  logic [NSRC-1:0] set_cond, edge_mode, clr_sw, clr_ack, clr_dtc, flag_d, seen_d;

  wire rd_st  = bus_sel & ~bus_wr & (bus_addr == AW'(ADDR_ST));
  wire wr_en  = bus_sel &  bus_wr & (bus_addr == AW'(ADDR_EN));
  wire wr_st  = bus_sel &  bus_wr & (bus_addr == AW'(ADDR_ST));
  wire wr_mlo = bus_sel &  bus_wr & (bus_addr == AW'(ADDR_MLO));
  wire wr_mhi = bus_sel &  bus_wr & (bus_addr == AW'(ADDR_MHI));

  for (genvar n = 0; n < NSRC; n++) begin : g_src
    wire fall = prev_q[n] & ~s2_q[n];
    wire rise = ~prev_q[n] & s2_q[n];
    always_comb begin
      unique case (mode_q[2*n +: 2])
        2'b00:   set_cond[n] = ~s2_q[n];
        2'b01:   set_cond[n] = fall;
        2'b10:   set_cond[n] = rise;
        default: set_cond[n] = fall | rise;
      endcase
    end
    assign edge_mode[n] = |mode_q[2*n +: 2];
  end

  assign clr_sw  = {NSRC{wr_st}} & ~bus_wdata[NSRC-1:0] & seen_q;
  assign clr_ack = ack_cpu_i & (edge_mode | s2_q);
  assign clr_dtc = dtc_ack_i & {NSRC{~dtc_keep_i}};
  assign flag_d  = set_cond | (flag_q & ~(clr_sw | clr_ack | clr_dtc));
  assign seen_d  = (seen_q | ({NSRC{rd_st}} & flag_q)) & flag_d;
  assign irq_o   = flag_q & en_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q   <= '1;
      s2_q   <= '1;
      prev_q <= '1;
      en_q   <= '0;
      flag_q <= '0;
      seen_q <= '0;
      mode_q <= '0;
    end else begin
      s1_q   <= pin_i;
      s2_q   <= s1_q;
      prev_q <= s2_q;
      flag_q <= flag_d;
      seen_q <= seen_d;
      if (wr_en)  en_q <= bus_wdata[NSRC-1:0];
      if (wr_mlo) mode_q[7:0] <= bus_wdata;
      if (wr_mhi) mode_q[MW-1:8] <= bus_wdata[HIW-1:0];
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_sel && !bus_wr) begin
      if (bus_addr == AW'(ADDR_EN))       bus_rdata = {{(8-NSRC){1'b0}}, en_q};
      else if (bus_addr == AW'(ADDR_ST))  bus_rdata = {{(8-NSRC){1'b0}}, flag_q};
      else if (bus_addr == AW'(ADDR_MLO)) bus_rdata = mode_q[7:0];
      else if (bus_addr == AW'(ADDR_MHI)) bus_rdata = {{(8-HIW){1'b0}}, mode_q[MW-1:8]};
    end
  end

  AST_FLAG_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    ((flag_q & ~$past(flag_q) & ~$past(set_cond)) == '0)); // R4
  AST_SW_CLEAR_NEEDS_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(flag_q) & ~flag_q & ~$past(ack_cpu_i | dtc_ack_i)
      & ~$past(seen_q & {NSRC{wr_st}} & ~bus_wdata[NSRC-1:0])) == '0)); // R6
  AST_EDGE_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(ack_cpu_i & edge_mode & ~set_cond) & flag_q) == '0)); // R7
  AST_LEVEL_ACK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(ack_cpu_i & ~edge_mode & ~s2_q & flag_q) & ~flag_q) == '0)); // R8
  AST_DTC_KEEP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(dtc_ack_i & {NSRC{dtc_keep_i}} & ~ack_cpu_i & ~clr_sw & flag_q) & ~flag_q) == '0)); // R9
  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(set_cond) & ~flag_q) == '0)); // R10
endmodule

// File: tb/test_ext_irq_sense.sv
module test_ext_irq_sense;
  localparam int CLK_P = 10;

  logic       clk = 0, rst_n = 0;
  logic [5:0] pin_i = '1, ack_cpu_i = '0, dtc_ack_i = '0, irq_o;
  logic       bus_sel = 0, bus_wr = 0, dtc_keep_i = 0;
  logic [1:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0, bus_rdata;
  int checks = 0, errors = 0;

  always #(CLK_P/2) clk = ~clk;

  ext_irq_sense i_ext_irq_sense (
    .clk(clk), .rst_n(rst_n), .pin_i(pin_i), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .ack_cpu_i(ack_cpu_i), .dtc_ack_i(dtc_ack_i), .dtc_keep_i(dtc_keep_i), .irq_o(irq_o));

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 0; bus_wr = 0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    bus_sel = 1; bus_wr = 0; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_sel = 0;
  endtask

  task automatic pulse_ack(input int n);
    ack_cpu_i[n] = 1'b1; @(negedge clk); ack_cpu_i[n] = 1'b0;
  endtask

  task automatic t_reset();
    logic [7:0] d;
    for (int a = 0; a < 4; a++) begin
      rd(2'(a), d); chk("R1 reset register", d, 8'h00);
    end
    chk("R1 reset irq", {2'b0, irq_o}, 8'h00);
  endtask

  task automatic t_regmap();
    logic [7:0] d;
    wr(0, 8'hFF); rd(0, d); chk("R2 enable unused bits", d, 8'h3F);
    wr(2, 8'hE4); rd(2, d); chk("R2 mode low register", d, 8'hE4);
    wr(3, 8'hFF); rd(3, d); chk("R2 mode high register", d, 8'h0F);
    wr(2, 8'h39); wr(3, 8'h05); wr(0, 8'h19);
    rd(0, d); chk("R2 enable readback", d, 8'h19);
  endtask

  task automatic t_falling();
    logic [7:0] d;
    pin_i[0] = 0;
    wait_n(2); chk("R4 latency not yet", {7'b0, irq_o[0]}, 8'h00);
    wait_n(1); chk("R4 falling sets", {7'b0, irq_o[0]}, 8'h01);
    rd(1, d); chk("R6 status read", d & 8'h01, 8'h01);
    wr(1, 8'h00); rd(1, d); chk("R6 clear after read", d & 8'h01, 8'h00);
    pin_i[0] = 1; wait_n(4);
    rd(1, d); chk("R5 rise ignored in falling mode", d & 8'h01, 8'h00);
  endtask

  task automatic t_rising();
    logic [7:0] d;
    pin_i[1] = 0; wait_n(4);
    rd(1, d); chk("R5 fall ignored in rising mode", d & 8'h02, 8'h00);
    pin_i[1] = 1; wait_n(3);
    rd(1, d); chk("R4 rising sets", d & 8'h02, 8'h02);
    pulse_ack(1);
    rd(1, d); chk("R7 ack clears rising", d & 8'h02, 8'h00);
  endtask

  task automatic t_both();
    logic [7:0] d;
    pin_i[2] = 0; wait_n(3);
    rd(1, d); chk("R4 both mode fall", d & 8'h04, 8'h04);
    pulse_ack(2);
    rd(1, d); chk("R7 ack clears both mode", d & 8'h04, 8'h00);
    pin_i[2] = 1; wait_n(3);
    rd(1, d); chk("R4 both mode rise", d & 8'h04, 8'h04);
    pulse_ack(2);
  endtask

  task automatic t_level();
    pin_i[3] = 0; wait_n(3);
    chk("R3 irq follows flag and enable", {2'b0, irq_o}, 8'h08);
    pulse_ack(3);
    chk("R8 ack with pin low keeps flag", {7'b0, irq_o[3]}, 8'h01);
    pin_i[3] = 1; wait_n(3);
    chk("R8 flag stays after pin high", {7'b0, irq_o[3]}, 8'h01);
    wr(0, 8'h11);
    chk("R3 disabled source gives no irq", {7'b0, irq_o[3]}, 8'h00);
    wr(0, 8'h19);
    pulse_ack(3);
    chk("R8 ack with pin high clears", {7'b0, irq_o[3]}, 8'h00);
  endtask

  task automatic t_swclear();
    logic [7:0] d;
    pin_i[4] = 0; wait_n(3);
    chk("R4 falling sets src4", {7'b0, irq_o[4]}, 8'h01);
    wr(1, 8'h00);
    chk("R6 zero write without read ignored", {7'b0, irq_o[4]}, 8'h01);
    rd(1, d);
    wr(1, 8'hFF);
    chk("R6 one write ignored", {7'b0, irq_o[4]}, 8'h01);
    wr(1, 8'hEF);
    chk("R6 zero write after read clears", {7'b0, irq_o[4]}, 8'h00);
  endtask

  task automatic t_dtc();
    logic [7:0] d;
    pin_i[5] = 0; wait_n(3);
    dtc_keep_i = 1; dtc_ack_i[5] = 1; @(negedge clk); dtc_ack_i[5] = 0;
    rd(1, d); chk("R9 keep leaves flag", d & 8'h20, 8'h20);
    dtc_keep_i = 0; dtc_ack_i[5] = 1; @(negedge clk); dtc_ack_i[5] = 0;
    rd(1, d); chk("R9 service clears flag", d & 8'h20, 8'h00);
  endtask

  task automatic t_setwins();
    pin_i[0] = 0; wait_n(3);
    pin_i[0] = 1; wait_n(3);
    chk("R4 src0 flag pending", {7'b0, irq_o[0]}, 8'h01);
    pin_i[0] = 0; wait_n(2);
    pulse_ack(0);
    chk("R10 set beats ack", {7'b0, irq_o[0]}, 8'h01);
    pulse_ack(0);
    chk("R7 later ack clears", {7'b0, irq_o[0]}, 8'h00);
  endtask

  initial begin
    #(CLK_P * 200000);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    wait_n(3); rst_n = 1; wait_n(1);
    t_reset(); t_regmap(); t_falling(); t_rising(); t_both();
    t_level(); t_swclear(); t_dtc(); t_setwins();
    wait_n(2);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule